// File: doc/BRIEF.md
# TDM Daisy-Chain Slot Splitter

This block is the serial-port front end of the device that sits next to the DSP in a chain of two audio devices. Both devices share one time-division-multiplexed frame. The frame is clocked by a bit clock and marked by a one-bit-wide frame sync. The near device keeps the slots addressed to it as eight parallel channel words. It re-sends the slots addressed to the far device on forwarding lines. The far device therefore finds its own data at the start of its frame, one bit clock later, with a matching re-timed frame sync.

A mode input selects one of two lane layouts. In single-line mode one input line carries sixteen 32-bit slots. The far device owns the earlier eight slots and the near device owns the later eight. In dual-line mode two input lines each carry eight 32-bit slots. On each line the far device owns the earlier four slots and the near device owns the later four. Line 0 carries the first four channels (L1, R1, L2, R2) and line 1 carries the last four (L3, R3, L4, R4). Each input line has its own forwarding line. Whenever a forwarding line is not echoing far-device data, it drives zero.

The bit clock is the block clock. Frame sync is high in the cycle that presents bit 0 of the frame, which is the MSB of slot 0.

Top module: `tdm_chain_splitter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sdOut0`, `sdOut1`, `fsOut` and `chanValid` are 0 and `chanData` is all zeros.
- R2: The cycle in which `frameSync` is high is bit 0 of slot 0. Slots are 32 bits, MSB first. Once locked, a sync arrives exactly one frame length after the previous one. In single-line mode, for bit positions 0 to 255 of the frame, `sdOut0` equals `sdIn0` delayed by one clock.
- R3: In single-line mode, `sdOut0` is 0 for bit positions 256 to 511. `sdOut1` is always 0, and `sdIn1` has no effect on any output.
- R4: In single-line mode, input slot 8+k on `sdIn0` (k = 0..7) becomes channel word k. The first bit received is bit 31 of the word, and word k occupies `chanData[32k+31:32k]`.
- R5: In dual-line mode, for bit positions 0 to 127, each `sdOutN` equals `sdInN` delayed by one clock. For positions 128 to 255 both forwarding lines are 0.
- R6: In dual-line mode, slots 4 to 7 of `sdIn0` become words 0 to 3, and slots 4 to 7 of `sdIn1` become words 4 to 7. Both use the same MSB-first packing as in R4.
- R7: `fsOut` equals `frameSync` delayed by one clock.
- R8: `chanValid` is a one-cycle pulse in the cycle after the last bit of a frame (position 511 in single-line mode, 255 in dual-line mode). `chanData` changes only together with that pulse and then holds until the next one.
- R9: After reset and before the first `frameSync`, input data is ignored. Both forwarding lines stay 0, no pulse occurs and `chanData` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| dualMode | input | 1 | 0: single-line layout, 1: dual-line layout |
| frameSync | input | 1 | High in the cycle of frame bit 0 |
| sdIn0 | input | 1 | TDM input line 0 |
| sdIn1 | input | 1 | TDM input line 1 (used in dual-line mode) |
| fsOut | output | 1 | Frame sync re-timed by one clock |
| sdOut0 | output | 1 | Forwarding line 0 |
| sdOut1 | output | 1 | Forwarding line 1 (dual-line mode) |
| chanValid | output | 1 | Pulse: a new set of channel words is present |
| chanData | output | 256 | Eight 32-bit local channel words, word k at bits 32k+31:32k |

## Verification
The assertions take two things for granted. First, once the first sync has been seen, every later sync falls exactly one frame length after the previous one. Second, the mode input changes only while reset is held, so the frame length never changes in the middle of a frame. The stimulus respects both. It sends frames back to back, with the sync on bit 0 of each frame. It changes the mode only inside a reset pulse. Before the first sync it sends only free-running data with the sync low. The data bits come from a seeded random source and are mixed with a few fixed patterns. In single-line mode the unused second line carries random data, so any leak from it would be visible.

// File: rtl/tdm_split_pkg.sv
`timescale 1ns/1ps
package tdm_split_pkg;
  // bits per TDM slot
  localparam int SLOT_W     = 32;
  // channels owned by this device
  localparam int LOCAL_CH   = 8;
  // slots in the single-line frame (both devices)
  localparam int FRAME_SLOTS = 2 * LOCAL_CH;
  localparam int SLOT_IDX_W = $clog2(FRAME_SLOTS);
  localparam int CH_IDX_W   = $clog2(LOCAL_CH);
  localparam int WORDS_W    = LOCAL_CH * SLOT_W;

  // strobes from the frame controller to the datapath
  typedef struct packed {
    logic                frameStart;
    logic                fwd0;
    logic                fwd1;
    logic                cap0;
    logic                cap1;
    logic [CH_IDX_W-1:0] chan0;
    logic [CH_IDX_W-1:0] chan1;
    logic                lastBit;
  } split_ctl_t;
endpackage

// File: rtl/tdm_slot_ctrl.sv
`timescale 1ns/1ps
module tdm_slot_ctrl
  import tdm_split_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dualMode,
  input  logic       frameSync,
  output split_ctl_t ctl
);
  localparam int FRAME_SINGLE = FRAME_SLOTS * SLOT_W;
  localparam int FRAME_DUAL   = LOCAL_CH * SLOT_W;
  localparam int CNT_W        = $clog2(FRAME_SINGLE);
  localparam int SLOT_SHIFT   = $clog2(SLOT_W);
  localparam int HALF_LINE    = LOCAL_CH / 2;

  logic [CNT_W-1:0]      bitCnt;
  logic [CNT_W-1:0]      bitPos;
  logic [CNT_W-1:0]      lastPos;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic                  locked;
  logic                  active;

  assign lastPos = dualMode ? CNT_W'(FRAME_DUAL - 1) : CNT_W'(FRAME_SINGLE - 1);
  assign active  = locked || frameSync;

  // position of the bit presented in this cycle
  always_comb begin
    if (frameSync)
      bitPos = '0;
    else if (bitCnt == lastPos)
      bitPos = '0;
    else
      bitPos = bitCnt + 1'b1;
  end

  assign slotIdx = SLOT_IDX_W'(bitPos >> SLOT_SHIFT);

  always_comb begin
    ctl            = '0;
    ctl.frameStart = frameSync;
    ctl.lastBit    = active && (bitPos == lastPos);
    if (active) begin
      if (!dualMode) begin
        if (slotIdx < SLOT_IDX_W'(LOCAL_CH)) begin
          ctl.fwd0 = 1'b1;
        end else begin
          ctl.cap0  = 1'b1;
          ctl.chan0 = CH_IDX_W'(slotIdx - SLOT_IDX_W'(LOCAL_CH));
        end
      end else begin
        if (slotIdx < SLOT_IDX_W'(HALF_LINE)) begin
          ctl.fwd0 = 1'b1;
          ctl.fwd1 = 1'b1;
        end else begin
          ctl.cap0  = 1'b1;
          ctl.cap1  = 1'b1;
          ctl.chan0 = CH_IDX_W'(slotIdx - SLOT_IDX_W'(HALF_LINE));
          ctl.chan1 = CH_IDX_W'(slotIdx);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      locked <= 1'b0;
    end else begin
      bitCnt <= bitPos;
      locked <= locked | frameSync;
    end
  end

  // input contract: after lock, sync lands exactly on a frame boundary
  AST_SYNC_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (locked && frameSync) |-> (bitCnt == lastPos))
    else $error("frame sync off the frame boundary"); // R2

endmodule

// File: rtl/tdm_slot_dpath.sv
`timescale 1ns/1ps
module tdm_slot_dpath
  import tdm_split_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  split_ctl_t         ctl,
  input  logic               sdIn0,
  input  logic               sdIn1,
  output logic               fsOut,
  output logic               sdOut0,
  output logic               sdOut1,
  output logic               chanValid,
  output logic [WORDS_W-1:0] chanData
);

  // forwarding path: one bit clock of delay, zero when not forwarding
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsOut     <= 1'b0;
      sdOut0    <= 1'b0;
      sdOut1    <= 1'b0;
      chanValid <= 1'b0;
    end else begin
      fsOut     <= ctl.frameStart;
      sdOut0    <= ctl.fwd0 ? sdIn0 : 1'b0;
      sdOut1    <= ctl.fwd1 ? sdIn1 : 1'b0;
      chanValid <= ctl.lastBit;
    end
  end

  // one shift register and one holding word per local channel
  for (genvar c = 0; c < LOCAL_CH; c++) begin : gChan
    logic [SLOT_W-1:0] shiftQ;
    logic [SLOT_W-1:0] shiftD;
    logic [SLOT_W-1:0] wordQ;
    logic              take0;
    logic              take1;

    assign take0 = ctl.cap0 && (ctl.chan0 == CH_IDX_W'(c));
    assign take1 = ctl.cap1 && (ctl.chan1 == CH_IDX_W'(c));

    always_comb begin
      if (take0)
        shiftD = {shiftQ[SLOT_W-2:0], sdIn0};
      else if (take1)
        shiftD = {shiftQ[SLOT_W-2:0], sdIn1};
      else
        shiftD = shiftQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftQ <= '0;
        wordQ  <= '0;
      end else begin
        shiftQ <= shiftD;
        if (ctl.lastBit)
          wordQ <= shiftD;
      end
    end

    assign chanData[c*SLOT_W +: SLOT_W] = wordQ;
  end

  AST_FWD_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.fwd0) |-> (sdOut0 == $past(sdIn0)))
    else $error("forwarded bit differs from input"); // R2

  AST_FWD_MUTE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.fwd0) |-> !sdOut0)
    else $error("forwarding line active outside far slots"); // R3

  AST_FS_RETIME: assert property (@(posedge clk) disable iff (!rstN)
    fsOut == $past(ctl.frameStart))
    else $error("re-timed sync misaligned"); // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    chanValid |=> !chanValid)
    else $error("valid longer than one cycle"); // R8

  AST_WORDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !chanValid |-> $stable(chanData))
    else $error("channel words changed without valid"); // R8

endmodule

// File: rtl/tdm_chain_splitter.sv
`timescale 1ns/1ps
module tdm_chain_splitter
  import tdm_split_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               dualMode,
  input  logic               frameSync,
  input  logic               sdIn0,
  input  logic               sdIn1,
  output logic               fsOut,
  output logic               sdOut0,
  output logic               sdOut1,
  output logic               chanValid,
  output logic [WORDS_W-1:0] chanData
);

  split_ctl_t ctl;

  tdm_slot_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dualMode  (dualMode),
    .frameSync (frameSync),
    .ctl       (ctl)
  );

  tdm_slot_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sdIn0     (sdIn0),
    .sdIn1     (sdIn1),
    .fsOut     (fsOut),
    .sdOut0    (sdOut0),
    .sdOut1    (sdOut1),
    .chanValid (chanValid),
    .chanData  (chanData)
  );

  AST_LINE1_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!dualMode && !$past(dualMode)) |-> !sdOut1)
    else $error("second forwarding line active in single-line mode"); // R3

endmodule

// File: tb/sim_tdm_chain_splitter.sv
`timescale 1ns/1ps
module sim_tdm_chain_splitter;
  import tdm_split_pkg::*;

  localparam int FW        = WORDS_W;
  localparam int MAX_BITS  = FRAME_SLOTS * SLOT_W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          dualMode = 1'b0;
  logic          frameSync = 1'b0;
  logic          sdIn0 = 1'b0;
  logic          sdIn1 = 1'b0;
  logic          fsOut, sdOut0, sdOut1, chanValid;
  logic [FW-1:0] chanData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // expectations for the outputs produced by the previously driven bit
  logic          eFwd0 = 1'b0, eFwd1 = 1'b0, eFs = 1'b0, eValid = 1'b0;
  logic [FW-1:0] eData = '0;
  string         tFwd0 = "R1", tFwd1 = "R1", tData = "R1", tFs = "R1", tValid = "R1";

  always #10 clk = ~clk;

  tdm_chain_splitter u0 (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .frameSync(frameSync),
    .sdIn0(sdIn0), .sdIn1(sdIn1), .fsOut(fsOut), .sdOut0(sdOut0),
    .sdOut1(sdOut1), .chanValid(chanValid), .chanData(chanData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic verifyPrev();
    check(sdOut0 === eFwd0, tFwd0, "sdOut0", FW'(sdOut0), FW'(eFwd0));
    check(sdOut1 === eFwd1, tFwd1, "sdOut1", FW'(sdOut1), FW'(eFwd1));
    check(fsOut === eFs, tFs, "fsOut", FW'(fsOut), FW'(eFs));
    check(chanValid === eValid, tValid, "chanValid", FW'(chanValid), FW'(eValid));
    check(chanData === eData, tData, "chanData", chanData, eData);
  endtask

  task automatic driveBit(input logic fs, input logic b0, input logic b1,
                          input logic x0, input logic x1, input string t0,
                          input string t1, input bit isLast,
                          input logic [FW-1:0] words, input string dTag);
    @(negedge clk);
    verifyPrev();
    frameSync = fs;
    sdIn0     = b0;
    sdIn1     = b1;
    eFwd0 = x0; eFwd1 = x1; eFs = fs; eValid = isLast;
    tFwd0 = t0; tFwd1 = t1; tFs = "R7"; tValid = "R8";
    if (isLast) eData = words;
    tData = dTag;
  endtask

  // expected channel words: R4 (single) and R6 (dual)
  function automatic logic [FW-1:0] expWords(input bit dual,
      input logic [MAX_BITS-1:0] a0, input logic [MAX_BITS-1:0] a1);
    logic [FW-1:0] w = '0;
    for (int k = 0; k < LOCAL_CH; k++) begin
      for (int b = 0; b < SLOT_W; b++) begin
        if (!dual)
          w[k*SLOT_W + SLOT_W-1-b] = a0[(LOCAL_CH + k)*SLOT_W + b];
        else if (k < LOCAL_CH/2)
          w[k*SLOT_W + SLOT_W-1-b] = a0[(LOCAL_CH/2 + k)*SLOT_W + b];
        else
          w[k*SLOT_W + SLOT_W-1-b] = a1[k*SLOT_W + b];
      end
    end
    return w;
  endfunction

  task automatic sendFrame(input bit dual, input logic [MAX_BITS-1:0] a0,
                           input logic [MAX_BITS-1:0] a1);
    int len    = dual ? MAX_BITS/2 : MAX_BITS;
    int fwdLen = dual ? MAX_BITS/4 : MAX_BITS/2;
    logic [FW-1:0] w = expWords(dual, a0, a1);
    for (int i = 0; i < len; i++) begin
      logic x0 = (i < fwdLen) ? a0[i] : 1'b0;
      logic x1 = (dual && i < fwdLen) ? a1[i] : 1'b0;
      string t0 = dual ? "R5" : ((i < fwdLen) ? "R2" : "R3");
      string t1 = dual ? "R5" : "R3";
      driveBit(i == 0, a0[i], a1[i], x0, x1, t0, t1, i == len-1, w,
               dual ? "R6" : "R4");
    end
  endtask

  function automatic logic [MAX_BITS-1:0] randBits();
    logic [MAX_BITS-1:0] r;
    for (int k = 0; k < MAX_BITS/32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic resetDut(input bit dual);
    @(negedge clk);
    rstN = 1'b0; dualMode = dual; frameSync = 1'b0; sdIn0 = 1'b0; sdIn1 = 1'b0;
    repeat (3) @(negedge clk);
    eFwd0 = 0; eFwd1 = 0; eFs = 0; eValid = 0; eData = '0;
    tFwd0 = "R1"; tFwd1 = "R1"; tFs = "R1"; tValid = "R1"; tData = "R1";
    verifyPrev();            // R1: state while reset held
    rstN = 1'b1;
  endtask

  task automatic preLock();
    // R9: data with no sync yet must not pass or be captured
    for (int i = 0; i < 80; i++)
      driveBit(1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0, "R9", "R9",
               1'b0, '0, "R9");
  endtask

  initial begin
    logic [MAX_BITS-1:0] p0, p1;
    void'($urandom(32'd4242));

    // single-line layout
    resetDut(1'b0);
    preLock();
    for (int f = 0; f < 3; f++) sendFrame(1'b0, randBits(), randBits());
    p0 = '1; p1 = '1;                       // all ones: unused slots must stay 0
    sendFrame(1'b0, p0, p1);
    p0 = '0;                                // far slots zero, local slots numbered
    for (int k = 0; k < LOCAL_CH; k++) p0[(LOCAL_CH+k)*SLOT_W +: SLOT_W] = 32'hA5000000 | k;
    sendFrame(1'b0, p0, randBits());

    // dual-line layout
    resetDut(1'b1);
    preLock();
    for (int f = 0; f < 4; f++) sendFrame(1'b1, randBits(), randBits());
    p0 = '1; p1 = '0;
    sendFrame(1'b1, p0, p1);
    sendFrame(1'b1, p1, p0);

    @(negedge clk);
    verifyPrev();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nFails++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule